// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits between a processor core and an external bus on which address and data share the same pins. The core hands it one transfer at a time. Each transfer carries an address, a read/write flag, a memory/I/O flag, write data, an upper-byte enable, an interrupt-enable flag and a segment code. The sequencer then walks a fixed chain of clock states. The first state, T1, presents the address and pulses the address latch enable so that external latches can hold it. In T2 the strobes and the data enable open. T3 follows, or a run of wait states (Tw) when the target is slow. T4 closes the cycle. After T1, the upper address pins change over to carry status bits.

Read data is captured at the clock edge that ends T3. A single-clock completion pulse, and for reads a data-valid pulse, are raised during T4. A hold request from another bus master is granted only between transfers. While the grant is active, every driven bus output except the address latch enable is released through a common enable.

States: `ST_IDLE`, `ST_T1`, `ST_T2`, `ST_TW`, `ST_T3`, `ST_T4`, `ST_HOLD`. Transitions:
- IDLE→HOLD when hold is high.
- IDLE→T1 when a request is present and hold is low.
- T1→T2 always.
- T2→TW and TW→TW when ready is low.
- T2→T3 and TW→T3 when ready is high.
- T3→T4 always.
- T4→HOLD when hold is high; T4→IDLE otherwise.
- HOLD→HOLD while hold is high; HOLD→IDLE once it drops.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset the block is idle: `ale`=0, `rd_n`=`wr_n`=1, `den`=0, `hlda`=0, `done`=0, `rdata_valid`=0, `bus_oe`=1, `ad_oe`=0.
- R2: A request seen in IDLE with `hold` low starts T1 on the next clock. During T1 only, `ale`=1, `ad_oe`=1, `ad_out` carries address bits 15:0 and `a_hi_out` carries address bits 19:16.
- R3: From T2 through T4, `a_hi_out` carries status: bit 3 = 0, bit 2 = the request's interrupt-enable flag, bits 1:0 = the segment code.
- R4: In T2, every Tw and T3, `den`=1. In the same states `rd_n`=0 for a read, or `wr_n`=0 for a write. In T1, T4 and idle both strobes are 1 and `den`=0. The two strobes are never low together.
- R5: For a write, `ad_oe`=1 and `ad_out` equals the write data from T2 through T4. For a read, `ad_oe`=0 after T1.
- R6: `ready` is sampled at the clock ending T2 and at each clock ending a Tw. Low inserts a Tw and high moves to T3, so a cycle with N low samples lasts 4+N clocks from T1 to T4.
- R7: `rdata` takes `ad_in` at the clock edge ending T3 of a read. `rdata_valid` is 1 for exactly the T4 clock of a read. `done` is 1 for exactly the T4 clock of every cycle.
- R8: From T1 through T4, `dtr` equals the write flag, `io_sel` the I/O flag (1 = I/O), and `bhe_n` the inverse of the upper-byte enable. In idle `dtr`=0, `io_sel`=0 and `bhe_n`=1.
- R9: `hold` is acted on only in IDLE or T4. The next state is HOLD, with `hlda`=1, `bus_oe`=0 and `ale`=0. HOLD lasts while `hold` is 1 and returns to IDLE one clock after it falls. A hold raised during a cycle does not lengthen or alter that cycle.
- R10: `req_valid` is ignored outside IDLE. In IDLE, `hold` has priority over it. Each accepted request produces exactly one `ale` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request from the core |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata | input | 16 | Write data |
| req_bhe | input | 1 | Upper data byte enable |
| req_ie | input | 1 | Interrupt-enable flag for status |
| req_seg | input | 2 | Segment code for status |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | One-clock pulse: read data valid |
| done | output | 1 | One-clock pulse: cycle complete |
| ad_out | output | 16 | Shared address/data pins, driven value |
| ad_in | input | 16 | Shared address/data pins, received value |
| ad_oe | output | 1 | Drive enable for the shared pins |
| a_hi_out | output | 4 | Upper address, then status |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Data buffer enable |
| dtr | output | 1 | Data direction, 1 = transmit |
| io_sel | output | 1 | 1 = I/O cycle |
| bhe_n | output | 1 | Upper byte enable, active low |
| bus_oe | output | 1 | Common enable for address, status and control pins |
| ready | input | 1 | Target ready, low requests wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |

## Verification
The bound checker watches several rules on every clock:
- the two strobes are never active together, and neither is active while `ale` is high;
- `ale` and `done` are single-clock pulses, and a data-valid pulse always comes with `done`;
- a write strobe implies driven pins and a read strobe implies released pins;
- a grant only begins after a clock with no strobe or address phase.

Some behaviours only the bench's scenarios can show: the exact number of inserted wait states for a given `ready` pattern, the values of the address, status and write data, the captured read word, and a hold raised mid-cycle taking effect only after T4. The same applies to requests being ignored under hold or mid-cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       hold,
    output bus_state_e state,
    output logic       accept
);

    bus_state_e nxt;

    assign accept = (state == ST_IDLE) && req_valid && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold) begin
                    nxt = ST_HOLD;
                end else if (req_valid) begin
                    nxt = ST_T1;
                end
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ready ? ST_T3 : ST_TW;
            ST_TW:   nxt = ready ? ST_T3 : ST_TW;
            ST_T3:   nxt = ST_T4;
            ST_T4:   nxt = hold ? ST_HOLD : ST_IDLE;
            ST_HOLD: nxt = hold ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/mbs_latch.sv
module mbs_latch
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_bhe,
    input  logic              req_ie,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] l_addr,
    output logic              l_write,
    output logic              l_io,
    output logic [DATA_W-1:0] l_wdata,
    output logic              l_bhe,
    output logic              l_ie,
    output logic [SEG_W-1:0]  l_seg,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_addr  <= '0;
            l_write <= 1'b0;
            l_io    <= 1'b0;
            l_wdata <= '0;
            l_bhe   <= 1'b0;
            l_ie    <= 1'b0;
            l_seg   <= '0;
        end else if (accept) begin
            l_addr  <= req_addr;
            l_write <= req_write;
            l_io    <= req_io;
            l_wdata <= req_wdata;
            l_bhe   <= req_bhe;
            l_ie    <= req_ie;
            l_seg   <= req_seg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
            done        <= 1'b0;
        end else begin
            if (state == ST_T3 && !l_write) begin
                rdata <= ad_in;
            end
            rdata_valid <= (state == ST_T3) && !l_write;
            done        <= (state == ST_T3);
        end
    end

endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  bus_state_e              state,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic                    l_write,
    input  logic                    l_io,
    input  logic [DATA_W-1:0]       l_wdata,
    input  logic                    l_bhe,
    input  logic                    l_ie,
    input  logic [SEG_W-1:0]        l_seg,
    output logic [DATA_W-1:0]       ad_out,
    output logic                    ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi_out,
    output logic                    ale,
    output logic                    rd_n,
    output logic                    wr_n,
    output logic                    den,
    output logic                    dtr,
    output logic                    io_sel,
    output logic                    bhe_n,
    output logic                    bus_oe,
    output logic                    hlda
);

    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int PAD_W = HI_W - SEG_W - 1;

    logic [HI_W-1:0] status;
    logic            in_cycle;
    logic            strobe;

    assign status = {{PAD_W{1'b0}}, l_ie, l_seg};

    always_comb begin
        in_cycle = 1'b0;
        strobe   = 1'b0;
        ale      = 1'b0;
        hlda     = 1'b0;
        bus_oe   = 1'b1;
        ad_out   = l_wdata;
        a_hi_out = '0;
        unique case (state)
            ST_T1: begin
                in_cycle = 1'b1;
                ale      = 1'b1;
                ad_out   = l_addr[DATA_W-1:0];
                a_hi_out = l_addr[ADDR_W-1:DATA_W];
            end
            ST_T2, ST_TW, ST_T3: begin
                in_cycle = 1'b1;
                strobe   = 1'b1;
                a_hi_out = status;
            end
            ST_T4: begin
                in_cycle = 1'b1;
                a_hi_out = status;
            end
            ST_HOLD: begin
                hlda   = 1'b1;
                bus_oe = 1'b0;
            end
            default: begin
                in_cycle = 1'b0;
            end
        endcase
        ad_oe  = ale || (l_write && in_cycle);
        rd_n   = !(strobe && !l_write);
        wr_n   = !(strobe && l_write);
        den    = strobe;
        dtr    = in_cycle && l_write;
        io_sel = in_cycle && l_io;
        bhe_n  = !(in_cycle && l_bhe);
    end

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic                     req_io,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_bhe,
    input  logic                     req_ie,
    input  logic [SEG_W-1:0]         req_seg,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic                     done,
    output logic [DATA_W-1:0]        ad_out,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi_out,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den,
    output logic                     dtr,
    output logic                     io_sel,
    output logic                     bhe_n,
    output logic                     bus_oe,
    input  logic                     ready,
    input  logic                     hold,
    output logic                     hlda
);

    bus_state_e        state;
    logic              accept;
    logic [ADDR_W-1:0] l_addr;
    logic              l_write;
    logic              l_io;
    logic [DATA_W-1:0] l_wdata;
    logic              l_bhe;
    logic              l_ie;
    logic [SEG_W-1:0]  l_seg;

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .hold      (hold),
        .state     (state),
        .accept    (accept)
    );

    mbs_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_io      (req_io),
        .req_wdata   (req_wdata),
        .req_bhe     (req_bhe),
        .req_ie      (req_ie),
        .req_seg     (req_seg),
        .ad_in       (ad_in),
        .l_addr      (l_addr),
        .l_write     (l_write),
        .l_io        (l_io),
        .l_wdata     (l_wdata),
        .l_bhe       (l_bhe),
        .l_ie        (l_ie),
        .l_seg       (l_seg),
        .rdata       (rdata),
        .rdata_valid (rdata_valid),
        .done        (done)
    );

    mbs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_drive (
        .state    (state),
        .l_addr   (l_addr),
        .l_write  (l_write),
        .l_io     (l_io),
        .l_wdata  (l_wdata),
        .l_bhe    (l_bhe),
        .l_ie     (l_ie),
        .l_seg    (l_seg),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .a_hi_out (a_hi_out),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .den      (den),
        .dtr      (dtr),
        .io_sel   (io_sel),
        .bhe_n    (bhe_n),
        .bus_oe   (bus_oe),
        .hlda     (hlda)
    );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den,
    input logic ad_oe,
    input logic bus_oe,
    input logic hlda,
    input logic done,
    input logic rdata_valid
);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_no_strobe_in_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && !den));

    assert_strobe_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> den);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    assert_write_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> done);

    assert_grant_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !ale));

    assert_grant_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(rd_n && wr_n && !ale));

endmodule

bind mux_bus_sequencer mbs_checker u_mbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .den         (den),
    .ad_oe       (ad_oe),
    .bus_oe      (bus_oe),
    .hlda        (hlda),
    .done        (done),
    .rdata_valid (rdata_valid)
);

// File: tb/mux_bus_sequencer_test.sv
module mux_bus_sequencer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_bhe = 1'b0;
    logic        req_ie = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic        done;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic        ad_oe;
    logic [3:0]  a_hi_out;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        den;
    logic        dtr;
    logic        io_sel;
    logic        bhe_n;
    logic        bus_oe;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;

    int checks = 0;
    int errors = 0;
    int ale_count = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .req_bhe(req_bhe), .req_ie(req_ie), .req_seg(req_seg),
        .rdata(rdata), .rdata_valid(rdata_valid), .done(done),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi_out(a_hi_out),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den(den), .dtr(dtr),
        .io_sel(io_sel), .bhe_n(bhe_n), .bus_oe(bus_oe), .ready(ready),
        .hold(hold), .hlda(hlda)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1..5 = T1,T2,Tw,T3,T4, 6 = granted
    int          m_ph = 0;
    logic [19:0] m_addr = '0;
    logic        m_wr = 0, m_io = 0, m_bhe = 0, m_ie = 0;
    logic [1:0]  m_seg = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (hold) m_ph = 6;
                   else if (req_valid) begin
                       m_addr = req_addr; m_wr = req_write; m_io = req_io;
                       m_bhe = req_bhe; m_ie = req_ie; m_seg = req_seg;
                       m_wdata = req_wdata; m_ph = 1;
                   end
                1: m_ph = 2;
                2, 3: m_ph = ready ? 4 : 3;
                4: begin
                    if (!m_wr) m_rdata = ad_in;
                    m_ph = 5;
                end
                5: m_ph = hold ? 6 : 0;
                default: m_ph = hold ? 6 : 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && ale) ale_count++;
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit cyc = (m_ph >= 1 && m_ph <= 5);
            automatic bit stb = (m_ph >= 2 && m_ph <= 4);
            chk("R9 bus_oe", bus_oe, m_ph != 6);
            chk("R9 hlda", hlda, m_ph == 6);
            chk("R2 ale", ale, m_ph == 1);
            if (m_ph != 6) begin
                chk("R4 rd_n", rd_n, !(stb && !m_wr));
                chk("R4 wr_n", wr_n, !(stb && m_wr));
                chk("R4 den", den, stb);
                chk("R8 dtr", dtr, cyc && m_wr);
                chk("R8 io_sel", io_sel, cyc && m_io);
                chk("R8 bhe_n", bhe_n, !(cyc && m_bhe));
                chk("R5 ad_oe", ad_oe, (m_ph == 1) || (cyc && m_wr));
                if (m_ph == 1) begin
                    chk("R2 address low", ad_out, m_addr[15:0]);
                    chk("R2 address high", a_hi_out, m_addr[19:16]);
                end
                if (m_ph >= 2 && m_ph <= 5) begin
                    chk("R3 status", a_hi_out, {1'b0, m_ie, m_seg});
                    if (m_wr) chk("R5 write data", ad_out, m_wdata);
                end
            end
            chk("R7 done", done, m_ph == 5);
            chk("R7 rdata_valid", rdata_valid, m_ph == 5 && !m_wr);
            if (m_ph == 5 && !m_wr) chk("R7 rdata", rdata, m_rdata);
        end
    end

    task automatic do_cycle(input logic [19:0] a, input logic wr, input logic io,
                            input logic bhe, input logic ie, input logic [1:0] seg,
                            input logic [15:0] wd, input logic [15:0] rdv,
                            input int waits, input bit hold_mid, input bit poke);
        int n;
        int ale0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_io = io; req_bhe = bhe;
        req_ie = ie; req_seg = seg; req_wdata = wd; ad_in = rdv;
        ready = (waits == 0);
        ale0 = ale_count;
        @(negedge clk);
        req_valid = 0;
        n = 1;
        if (hold_mid) hold = 1;
        chk("R2 ale in first state", ale, 1);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (n == waits + 2) ready = 1;
            if (poke && n == 2) begin req_valid = 1; req_addr = ~a; end
            if (poke && n == 3) req_valid = 0;
        end
        chk("R6 cycle length", n, 4 + waits);
        if (!wr) chk("R7 read word", rdata, rdv);
        chk("R10 one address phase", ale_count - ale0, 1);
        ready = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ale", ale, 0);
        chk("R1 rd_n", rd_n, 1);
        chk("R1 wr_n", wr_n, 1);
        chk("R1 hlda", hlda, 0);
        chk("R1 bus_oe", bus_oe, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 rdata_valid", rdata_valid, 0);
        chk("R1 den", den, 0);
        chk("R1 ad_oe", ad_oe, 0);

        do_cycle(20'h5A3C7, 0, 0, 1, 1, 2'd2, 16'h0000, 16'hBEEF, 0, 0, 0);
        do_cycle(20'h0F0F1, 1, 1, 1, 0, 2'd1, 16'h1234, 16'h0000, 0, 0, 0);
        do_cycle(20'hA0010, 0, 1, 0, 1, 2'd0, 16'h0000, 16'h8001, 2, 0, 0);
        do_cycle(20'h3FFFE, 1, 0, 0, 1, 2'd3, 16'hCAFE, 16'h0000, 1, 0, 0);
        do_cycle(20'hFFFFF, 0, 0, 1, 0, 2'd3, 16'h0000, 16'h7E57, 3, 0, 0);

        // R10: a request raised mid-cycle is ignored
        do_cycle(20'h12345, 0, 1, 1, 1, 2'd1, 16'h0000, 16'h0F0F, 1, 0, 1);
        @(negedge clk);
        chk("R10 no cycle from ignored request", ale, 0);

        // R9/R10: hold in idle outranks a pending request
        begin
            int ale0;
            int guard;
            @(negedge clk);
            hold = 1; req_valid = 1; req_addr = 20'h9ABCD; req_write = 0;
            req_io = 0; req_bhe = 1; req_ie = 0; req_seg = 2'd2; ad_in = 16'hC0DE;
            ale0 = ale_count;
            repeat (3) @(negedge clk);
            chk("R9 grant in idle", hlda, 1);
            chk("R9 floated", bus_oe, 0);
            chk("R10 hold beats request", ale_count - ale0, 0);
            hold = 0;
            @(negedge clk);
            chk("R9 grant released", hlda, 0);
            guard = 0;
            while (!ale && guard < 10) begin @(negedge clk); guard++; end
            req_valid = 0;
            chk("R10 request taken after release", ale, 1);
            guard = 0;
            while (!done && guard < 10) begin @(negedge clk); guard++; end
            chk("R7 read word after hold", rdata, 16'hC0DE);
        end

        // R9: hold raised in T1 lets the cycle finish first
        do_cycle(20'h00F00, 1, 0, 1, 1, 2'd0, 16'h5AA5, 16'h0000, 2, 1, 0);
        @(negedge clk);
        chk("R9 grant after cycle", hlda, 1);
        chk("R9 ale low in grant", ale, 0);
        repeat (2) @(negedge clk);
        hold = 0;
        @(negedge clk);
        chk("R9 back to idle", hlda, 0);
        chk("R9 drive restored", bus_oe, 1);

        do_cycle(20'h76543, 0, 0, 0, 0, 2'd1, 16'h0000, 16'h0001, 0, 0, 0);
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule